// File: doc/BRIEF.md
# Dual-rate LFSR test pattern generator

This block is a built-in self-test stimulus source for a combinational or full-scan circuit under test. It holds two maximal-length Fibonacci LFSRs in one clock domain. The fast register steps on every pattern cycle. The slow register steps once every `d` pattern cycles, gated by an enable from a modulo-`d` counter. Circuit inputs fed from the slow register toggle far less often, which lowers switching power while the test is applied.

A static parameter map connects each output bit to one stage of either register. Several compatible outputs may share one slow stage. Software loads the seeds, picks the divide ratio and the test length, and pulses `start`. The block then emits exactly that many registered patterns, each marked by `pat_valid`, and raises `done` with the last one. If `d` equals the fast register's period, the slow register steps only after the fast one has covered its whole sequence. Every combined pattern is then distinct up to the product of the two periods.

Top module: `dual_rate_tpg`

## Requirements
- R1: After reset, `pattern` is 0 and `pat_valid` and `done` are 0.
- R2: The fast field (`pattern[3:0]` = fast stages 0..3 with the defaults) changes on every consecutive valid pattern. The fast LFSR shifts toward the MSB and feeds the XOR of stages 3 and 2 into stage 0 (x^4+x^3+1), so from seed 1 the next state is 2. Its period is 15.
- R3: The slow field (`pattern[9:4]`) keeps its value between consecutive valid patterns unless the index of the new pattern, counted from 0 after start, is a multiple of the divide ratio `d`. At such an index it changes.
- R4: A divide ratio of 0 is treated as 1, so the slow field then changes on every pattern.
- R5: Map with the defaults: outputs 0..3 take fast stages 0..3, outputs 4..7 take slow stages 0..3, output 8 shares slow stage 0 and output 9 shares slow stage 1. Outputs that share a stage are always equal.
- R6: A zero seed is loaded as 1, and neither register field ever shows the all-zero state in a valid pattern.
- R7: After an accepted start with length N>0, exactly N patterns appear with `pat_valid` high on consecutive cycles. `done` rises together with the last one and stays high until the next accepted start. With N=0, no pattern appears and `done` rises in the cycle after start.
- R8: `start` and `seed_load` have no effect while a run is in progress.
- R9: With `d` = 15 and N = 225, all patterns are distinct and the slow field takes 15 different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle |
| seed_load | input | 1 | Load both seeds; accepted only when idle |
| seed_slow | input | SLOW_W | Seed for the slow register |
| seed_fast | input | FAST_W | Seed for the fast register |
| div_ratio | input | RATIO_W | Slow step interval d, captured at start |
| test_len | input | LEN_W | Number of patterns N, captured at start |
| pattern | output | NUM_IN | Registered test pattern |
| pat_valid | output | 1 | High in each cycle that carries a new pattern |
| done | output | 1 | Run finished; held until next accepted start |

## Verification
The hardest condition to reach is a wrap of the combined state. With the full ratio of 15, the slow register needs 225 patterns to finish its period, and only a full-length run shows that no pattern repeats. The bench runs that session, stores every pattern and compares them all pairwise. It also pokes `start` and `seed_load` in the middle of a run and compares the result with an undisturbed run from the same seeds.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  // Feedback tap mask for a maximal-length Fibonacci LFSR that shifts
  // toward the MSB; bit k set means stage k feeds the XOR.
  function automatic logic [31:0] lfsr_taps(input int w);
    logic [31:0] m;
    case (w)
      3:  m = 32'h0000_0006;
      4:  m = 32'h0000_000C;
      5:  m = 32'h0000_0014;
      6:  m = 32'h0000_0030;
      7:  m = 32'h0000_0060;
      8:  m = 32'h0000_00B8;
      9:  m = 32'h0000_0110;
      10: m = 32'h0000_0240;
      11: m = 32'h0000_0500;
      12: m = 32'h0000_0829;
      13: m = 32'h0000_100D;
      14: m = 32'h0000_2015;
      15: m = 32'h0000_6000;
      16: m = 32'h0000_D008;
      default: m = 32'h0000_000C;
    endcase
    return m;
  endfunction

  localparam int MAP_FIELD = 8;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] MASK = W'(tpg_pkg::lfsr_taps(W));
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & MASK);
  assign state = q;

  always_ff @(posedge clk) begin
    if (rst)
      q <= ONE;
    else if (load)
      q <= (seed == '0) ? ONE : seed;
    else if (step)
      q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/tpg_rate_div.sv
module tpg_rate_div #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] phase_q;
  logic [RATIO_W-1:0] ratio_eff;

  assign ratio_eff = (ratio == '0) ? RATIO_W'(1) : ratio;
  assign tick      = run && (phase_q == ratio_eff - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)
      phase_q <= '0;
    else if (run)
      phase_q <= tick ? '0 : phase_q + RATIO_W'(1);
  end
endmodule

// File: rtl/tpg_len_ctrl.sv
module tpg_len_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [LEN_W-1:0] len,
  output logic             running,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             run_q;

  assign running = run_q;
  assign last    = run_q && (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (accept) begin
      run_q <= (len != '0);
      cnt_q <= '0;
      len_q <= len;
    end else if (run_q) begin
      cnt_q <= cnt_q + LEN_W'(1);
      if (last) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_rate_tpg.sv
module dual_rate_tpg #(
  parameter int SLOW_W  = 4,
  parameter int FAST_W  = 4,
  parameter int NUM_IN  = 10,
  parameter int RATIO_W = 8,
  parameter int LEN_W   = 16,
  parameter logic [NUM_IN-1:0] IN_SLOW = 10'b11_1111_0000,
  parameter logic [NUM_IN*tpg_pkg::MAP_FIELD-1:0] IN_STAGE =
    {8'd1, 8'd0, 8'd3, 8'd2, 8'd1, 8'd0, 8'd3, 8'd2, 8'd1, 8'd0}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               seed_load,
  input  logic [SLOW_W-1:0]  seed_slow,
  input  logic [FAST_W-1:0]  seed_fast,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic [LEN_W-1:0]   test_len,
  output logic [NUM_IN-1:0]  pattern,
  output logic               pat_valid,
  output logic               done
);
  localparam int MF = tpg_pkg::MAP_FIELD;

  logic               running;
  logic               last;
  logic               accept;
  logic               tick;
  logic               load_ok;
  logic [RATIO_W-1:0] ratio_q;
  logic [SLOW_W-1:0]  slow_q;
  logic [FAST_W-1:0]  fast_q;
  logic [NUM_IN-1:0]  mapped;
  logic [NUM_IN-1:0]  pattern_q;
  logic               valid_q;
  logic               done_q;

  assign accept  = start && !running;
  assign load_ok = seed_load && !running;

  tpg_len_ctrl #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .accept(accept), .len(test_len),
    .running(running), .last(last)
  );

  tpg_rate_div #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst(rst), .clear(accept), .run(running),
    .ratio(ratio_q), .tick(tick)
  );

  tpg_lfsr #(.W(SLOW_W)) u_slow (
    .clk(clk), .rst(rst), .load(load_ok), .seed(seed_slow),
    .step(tick), .state(slow_q)
  );

  tpg_lfsr #(.W(FAST_W)) u_fast (
    .clk(clk), .rst(rst), .load(load_ok), .seed(seed_fast),
    .step(running), .state(fast_q)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_map
    localparam int IDX = int'(IN_STAGE[i*MF +: MF]);
    if (IN_SLOW[i]) begin : g_slow
      assign mapped[i] = slow_q[IDX];
    end else begin : g_fast
      assign mapped[i] = fast_q[IDX];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q   <= RATIO_W'(1);
      pattern_q <= '0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      valid_q <= running;
      if (running) pattern_q <= mapped;
      if (accept) begin
        ratio_q <= div_ratio;
        done_q  <= (test_len == '0);
      end else if (last) begin
        done_q <= 1'b1;
      end
    end
  end

  assign pattern   = pattern_q;
  assign pat_valid = valid_q;
  assign done      = done_q;
endmodule

// File: rtl/dual_rate_tpg_checker.sv
module dual_rate_tpg_checker #(
  parameter int NUM_IN  = 10,
  parameter int RATIO_W = 8,
  parameter logic [NUM_IN-1:0] IN_SLOW = 10'b11_1111_0000,
  parameter logic [NUM_IN*tpg_pkg::MAP_FIELD-1:0] IN_STAGE =
    {8'd1, 8'd0, 8'd3, 8'd2, 8'd1, 8'd0, 8'd3, 8'd2, 8'd1, 8'd0}
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [NUM_IN-1:0]  pattern,
  input logic               pat_valid,
  input logic               done,
  input logic [RATIO_W-1:0] ratio_q
);
  localparam int MF = tpg_pkg::MAP_FIELD;

  logic [RATIO_W-1:0] ph_q;
  logic [RATIO_W-1:0] r_eff;
  logic [NUM_IN-1:0]  slow_bits;
  logic [NUM_IN-1:0]  fast_bits;

  assign r_eff     = (ratio_q == '0) ? RATIO_W'(1) : ratio_q;
  assign slow_bits = pattern & IN_SLOW;
  assign fast_bits = pattern & ~IN_SLOW;

  // Index of the current pattern modulo the ratio, counted from the ports.
  always_ff @(posedge clk) begin
    if (rst || !pat_valid)
      ph_q <= (pat_valid && r_eff != RATIO_W'(1)) ? RATIO_W'(1) : '0;
    else
      ph_q <= (ph_q == r_eff - RATIO_W'(1)) ? '0 : ph_q + RATIO_W'(1);
  end

  // R3: slow outputs change only on a pattern whose index is a multiple of d
  p_slow_phase_r3: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && $past(pat_valid) && slow_bits != $past(slow_bits)) |-> ph_q == '0);

  // R2: fast outputs move on every consecutive pattern
  p_fast_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && $past(pat_valid)) |-> fast_bits != $past(fast_bits));

  // R6: neither register field is all zero in a valid pattern
  p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    pat_valid |-> (slow_bits != '0 && fast_bits != '0));

  // R7: done holds until a start and no pattern follows it
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && !pat_valid));

  // R5: outputs sharing a stage carry the same value
  for (genvar i = 0; i < NUM_IN; i++) begin : g_i
    for (genvar j = i + 1; j < NUM_IN; j++) begin : g_j
      if (IN_SLOW[i] == IN_SLOW[j] &&
          IN_STAGE[i*MF +: MF] == IN_STAGE[j*MF +: MF]) begin : g_pair
        p_share_r5: assert property (@(posedge clk) disable iff (rst)
          pattern[i] == pattern[j]);
      end
    end
  end
endmodule

bind dual_rate_tpg dual_rate_tpg_checker #(
  .NUM_IN(NUM_IN), .RATIO_W(RATIO_W), .IN_SLOW(IN_SLOW), .IN_STAGE(IN_STAGE)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .pattern(pattern),
  .pat_valid(pat_valid), .done(done), .ratio_q(ratio_q)
);

// File: tb/sim_dual_rate_tpg.sv
module sim_dual_rate_tpg;
  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       seed_load = 1'b0;
  logic [3:0] seed_slow = '0;
  logic [3:0] seed_fast = '0;
  logic [7:0] div_ratio = 8'd1;
  logic [15:0] test_len = '0;
  logic [9:0] pattern;
  logic       pat_valid;
  logic       done;

  int checks = 0;
  int fails  = 0;
  logic [9:0] cap [CAP];
  logic [9:0] ref_cap [CAP];
  int n_cap;
  bit done_with_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rate_tpg u0 (
    .clk(clk), .rst(rst), .start(start), .seed_load(seed_load),
    .seed_slow(seed_slow), .seed_fast(seed_fast), .div_ratio(div_ratio),
    .test_len(test_len), .pattern(pattern), .pat_valid(pat_valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_seeds(input logic [3:0] s, input logic [3:0] f);
    @(negedge clk);
    seed_slow = s; seed_fast = f; seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  // poke: 0 none, 1 start, 2 seed_load with other seeds, at capture index poke_at
  task automatic run(input int ratio, input int len, input int poke, input int poke_at);
    n_cap = 0;
    done_with_last = 1'b0;
    @(negedge clk);
    div_ratio = 8'(ratio); test_len = 16'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int it = 0; it < CAP; it++) begin
      start = 1'b0; seed_load = 1'b0;
      if (pat_valid) begin
        cap[n_cap] = pattern;
        n_cap++;
        if (poke == 1 && n_cap == poke_at) begin start = 1'b1; test_len = 16'd3; end
        if (poke == 2 && n_cap == poke_at) begin
          seed_load = 1'b1; seed_fast = 4'd9; seed_slow = 4'd7;
        end
      end
      if (done) begin
        done_with_last = pat_valid;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0; seed_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(pattern == '0, "R1 pattern", int'(pattern), 0);
    chk(!pat_valid, "R1 pat_valid", int'(pat_valid), 0);
    chk(!done, "R1 done", int'(done), 0);
  endtask

  task automatic t_zero_seed;
    load_seeds(4'd0, 4'd0);
    run(15, 1, 0, 0);
    chk(n_cap == 1, "R7 one pattern", n_cap, 1);
    chk(cap[0][3:0] == 4'd1, "R6 fast zero seed", int'(cap[0][3:0]), 1);
    chk(cap[0][7:4] == 4'd1, "R6 slow zero seed", int'(cap[0][7:4]), 1);
  endtask

  task automatic t_full_run;
    bit uniq = 1'b1;
    bit shared = 1'b1;
    bit slow_ok = 1'b1;
    bit fast_ok = 1'b1;
    bit [15:0] seen_slow = '0;
    bit [15:0] seen_fast = '0;
    load_seeds(4'd1, 4'd1);
    run(15, 225, 0, 0);
    chk(n_cap == 225, "R7 count", n_cap, 225);
    chk(done_with_last, "R7 done with last", int'(done_with_last), 1);
    chk(!pat_valid && done, "R7 idle after", int'(pat_valid), 0);
    chk(cap[1][3:0] == 4'd2, "R2 fast step from 1", int'(cap[1][3:0]), 2);
    chk(cap[15][7:4] == 4'd2, "R3 slow step at d", int'(cap[15][7:4]), 2);
    for (int k = 0; k < 15; k++) seen_fast[cap[k][3:0]] = 1'b1;
    chk(seen_fast[0] == 1'b0 && $countones(seen_fast) == 15, "R2 fast period",
        $countones(seen_fast), 15);
    chk(cap[15][3:0] == cap[0][3:0], "R2 fast wraps at 15", int'(cap[15][3:0]),
        int'(cap[0][3:0]));
    for (int k = 0; k < n_cap; k++) begin
      seen_slow[cap[k][7:4]] = 1'b1;
      if (cap[k][9:8] != cap[k][5:4]) shared = 1'b0;
      if (k > 0) begin
        if ((k % 15 == 0) != (cap[k][9:4] != cap[k-1][9:4])) slow_ok = 1'b0;
        if (cap[k][3:0] == cap[k-1][3:0]) fast_ok = 1'b0;
      end
      for (int j = 0; j < k; j++) if (cap[j] == cap[k]) uniq = 1'b0;
    end
    chk(uniq, "R9 all distinct", int'(uniq), 1);
    chk(!seen_slow[0] && $countones(seen_slow) == 15, "R9 slow period",
        $countones(seen_slow), 15);
    chk(shared, "R5 shared stages", int'(shared), 1);
    chk(slow_ok, "R3 slow change points d=15", int'(slow_ok), 1);
    chk(fast_ok, "R2 fast moves", int'(fast_ok), 1);
  endtask

  task automatic t_short_ratio;
    bit ok = 1'b1;
    load_seeds(4'd5, 4'd3);
    run(3, 12, 0, 0);
    chk(n_cap == 12, "R7 count d=3", n_cap, 12);
    for (int k = 1; k < n_cap; k++)
      if ((k % 3 == 0) != (cap[k][9:4] != cap[k-1][9:4])) ok = 1'b0;
    chk(ok, "R3 slow change points d=3", int'(ok), 1);
  endtask

  task automatic t_ratio_zero;
    bit ok = 1'b1;
    run(0, 6, 0, 0);
    for (int k = 1; k < n_cap; k++)
      if (cap[k][7:4] == cap[k-1][7:4]) ok = 1'b0;
    chk(ok && n_cap == 6, "R4 ratio 0 acts as 1", n_cap, 6);
  endtask

  task automatic t_len_zero;
    run(15, 0, 0, 0);
    chk(n_cap == 0, "R7 length 0 no pattern", n_cap, 0);
    chk(done, "R7 length 0 done", int'(done), 1);
  endtask

  task automatic t_pokes;
    bit same = 1'b1;
    load_seeds(4'd6, 4'd11);
    run(4, 20, 0, 0);
    for (int k = 0; k < 20; k++) ref_cap[k] = cap[k];
    load_seeds(4'd6, 4'd11);
    run(4, 20, 1, 5);
    chk(n_cap == 20, "R8 start ignored count", n_cap, 20);
    for (int k = 0; k < 20; k++) if (cap[k] != ref_cap[k]) same = 1'b0;
    chk(same, "R8 start ignored patterns", int'(same), 1);
    load_seeds(4'd6, 4'd11);
    run(4, 20, 2, 5);
    same = 1'b1;
    for (int k = 0; k < 20; k++) if (cap[k] != ref_cap[k]) same = 1'b0;
    chk(same && n_cap == 20, "R8 seed load ignored", int'(same), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_seed();
        t_full_run();
        t_short_ratio();
        t_ratio_zero();
        t_len_zero();
        t_pokes();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule